// File: doc/BRIEF.md
# SPI Fault-Status Register Slave

This block is an SPI slave that reports the fault state of a power-stage driver through two read-only status registers. A master sends one 16-bit command per chip-select frame. The word the slave shifts out during a frame answers the command of the previous valid frame. Reading a register therefore takes two frames: the read command, then a second frame (normally all-zero SDI) that clocks the answer out.

Raw fault events arrive on a vector of one-cycle pulses. Each event sets its own cause bit, and any event sets a fault summary bit and drives the active-low fault pin low. The summary bit and the pin stay set until reset. A cause bit clears once a read has returned it. A later read can therefore show the summary alone while the pin is still low. The SPI pins are sampled with the system clock through two-flop synchronizers, so SCLK must run well below the system clock.

Top module: `spi_fault_status`

## Requirements
- R1: A frame is the time cs_n is low. It is accepted only if exactly 16 SCLK cycles occur in it. SDI is sampled on falling SCLK and SDO changes on rising SCLK, MSB first. A frame with any other clock count changes neither the pending response nor any fault bit.
- R2: Command layout: bit 15 is the direction (1 = read, 0 = write), bits 14:11 are the register address, and bits 10:0 are data.
- R3: The SDO word in a frame answers the last accepted command. Its bit 15 is 0, bits 14:11 echo that command's address, and bits 10:0 hold the content the addressed register had at the end of the command frame. Before any accepted command the word is 0x0000. SDO is low while cs_n is high.
- R4: Address 0 holds the summary flag in bit 10 and the causes of events 0 to 9 in bits 9:0. Address 1 holds the causes of events 10 and 11 in bits 1:0. All other bits, and all other addresses, read as zero.
- R5: A one-cycle high pulse on fault_evt[i] sets cause bit i and the summary flag, and drives fault_n low within two clock cycles.
- R6: The summary flag and fault_n stay set until reset, whatever is read.
- R7: An accepted read clears, at the end of its frame, the cause bits of the addressed register that its response carries. It never clears the summary flag.
- R8: A write sets and clears no bits. Its response in the next frame is the current content of the addressed register.
- R9: A fault event in the same clock cycle as a clear-on-read of its bit leaves the bit set.
- R10: After reset, fault_n is high, every status bit is zero and the pending response is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI chip select, active low |
| sdi | input | 1 | SPI serial data in |
| sdo | output | 1 | SPI serial data out, low when idle |
| fault_evt | input | C0_W+C1_W | Raw fault event pulses, one per cause bit |
| fault_n | output | 1 | Latched fault indication, active low |

## Verification
Each SPI pin passes two synchronizer flops and an edge-detect stage. SDO therefore moves about three system clocks after a rising SCLK, and the bench samples it six clocks later, just before the falling edge. A frame is accepted, and its clear-on-read applied, on the third clock edge after cs_n rises. The bench injects a collision event at exactly that edge to exercise R9. Its other results are read as whole words one frame after the command, and fault_n is checked two clocks after an event pulse.

// File: rtl/spi_fault_pkg.sv
package spi_fault_pkg;
  localparam int FRAME_W  = 16;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 11;
  localparam int SUM_BIT  = 10;
  localparam int CNT_W    = $clog2(FRAME_W + 2);
  localparam logic [ADDR_W-1:0] ADDR_STAT0 = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT1 = 4'd1;
endpackage

// File: rtl/spi_fault_sync.sv
module spi_fault_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/spi_fault_shifter.sv
module spi_fault_shifter
  import spi_fault_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk_s,
  input  logic                cs_n_s,
  input  logic                sdi_s,
  input  logic [FRAME_W-1:0]  resp_word,
  output logic                sdo,
  output logic                frame_valid,
  output logic                cmd_rd,
  output logic [ADDR_W-1:0]   cmd_addr
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic               sclk_d, cs_d;
  logic [FRAME_W-1:0] rx_q, rx_d, tx_q, tx_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               sdo_q, sdo_d;
  logic               sclk_rise, sclk_fall, cs_fall, cs_rise;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign cs_fall   = ~cs_n_s & cs_d;
  assign cs_rise   = cs_n_s & ~cs_d;

  always_comb begin
    rx_d  = rx_q;
    tx_d  = tx_q;
    cnt_d = cnt_q;
    sdo_d = sdo_q;
    if (cs_fall) begin
      tx_d  = resp_word;
      cnt_d = '0;
      sdo_d = 1'b0;
    end else if (!cs_n_s) begin
      if (sclk_rise) begin
        sdo_d = tx_q[FRAME_W-1];
        tx_d  = {tx_q[FRAME_W-2:0], 1'b0};
      end
      if (sclk_fall) begin
        rx_d  = {rx_q[FRAME_W-2:0], sdi_s};
        cnt_d = (cnt_q == CNT_SAT) ? CNT_SAT : cnt_q + 1'b1;
      end
    end
    if (cs_n_s) sdo_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
      rx_q   <= '0;
      tx_q   <= '0;
      cnt_q  <= '0;
      sdo_q  <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_n_s;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      cnt_q  <= cnt_d;
      sdo_q  <= sdo_d;
    end
  end

  assign sdo         = sdo_q;
  assign frame_valid = cs_rise & (cnt_q == CNT_FULL);
  assign cmd_rd      = rx_q[FRAME_W-1];
  assign cmd_addr    = rx_q[FRAME_W-2 -: ADDR_W];
endmodule

// File: rtl/spi_fault_regs.sv
module spi_fault_regs
  import spi_fault_pkg::*;
#(
  parameter int C0_W = 10,
  parameter int C1_W = 2,
  localparam int EVT_W = C0_W + C1_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EVT_W-1:0]   evt,
  input  logic               frame_valid,
  input  logic               cmd_rd,
  input  logic [ADDR_W-1:0]  cmd_addr,
  output logic [FRAME_W-1:0] resp_word,
  output logic [EVT_W-1:0]   cause_o,
  output logic [EVT_W-1:0]   clr_o,
  output logic               fault_n
);
  logic [EVT_W-1:0]   cause_q, cause_d, clr;
  logic               sum_q, sum_d;
  logic [FRAME_W-1:0] resp_q, resp_d;
  logic [DATA_W-1:0]  stat0_w, stat1_w, rd_data;

  always_comb begin
    stat0_w = '0;
    stat1_w = '0;
    stat0_w[C0_W-1:0] = cause_q[C0_W-1:0];
    stat0_w[SUM_BIT]  = sum_q;
    stat1_w[C1_W-1:0] = cause_q[EVT_W-1:C0_W];
    case (cmd_addr)
      ADDR_STAT0: rd_data = stat0_w;
      ADDR_STAT1: rd_data = stat1_w;
      default:    rd_data = '0;
    endcase
  end

  always_comb begin
    clr = '0;
    if (frame_valid && cmd_rd) begin
      if (cmd_addr == ADDR_STAT0) clr[C0_W-1:0]     = cause_q[C0_W-1:0];
      if (cmd_addr == ADDR_STAT1) clr[EVT_W-1:C0_W] = cause_q[EVT_W-1:C0_W];
    end
    cause_d = (cause_q & ~clr) | evt;
    sum_d   = sum_q | (|evt);
    resp_d  = frame_valid ? {1'b0, cmd_addr, rd_data} : resp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      sum_q   <= 1'b0;
      resp_q  <= '0;
    end else begin
      cause_q <= cause_d;
      sum_q   <= sum_d;
      resp_q  <= resp_d;
    end
  end

  assign resp_word = resp_q;
  assign cause_o   = cause_q;
  assign clr_o     = clr;
  assign fault_n   = ~sum_q;
endmodule

// File: rtl/spi_fault_status.sv
module spi_fault_status
  import spi_fault_pkg::*;
#(
  parameter int C0_W = 10,
  parameter int C1_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk,
  input  logic                 cs_n,
  input  logic                 sdi,
  output logic                 sdo,
  input  logic [C0_W+C1_W-1:0] fault_evt,
  output logic                 fault_n
);
  localparam int EVT_W = C0_W + C1_W;

  logic               rst_meta, rst_s;
  logic [2:0]         pins_s;
  logic               frame_valid, cmd_rd;
  logic [ADDR_W-1:0]  cmd_addr;
  logic [FRAME_W-1:0] resp_word;
  logic [EVT_W-1:0]   cause_all, clr_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  spi_fault_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_s),
    .d     ({sclk, cs_n, sdi}),
    .q     (pins_s)
  );

  spi_fault_shifter u_shift (
    .clk         (clk),
    .rst_n       (rst_s),
    .sclk_s      (pins_s[2]),
    .cs_n_s      (pins_s[1]),
    .sdi_s       (pins_s[0]),
    .resp_word   (resp_word),
    .sdo         (sdo),
    .frame_valid (frame_valid),
    .cmd_rd      (cmd_rd),
    .cmd_addr    (cmd_addr)
  );

  spi_fault_regs #(.C0_W(C0_W), .C1_W(C1_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_s),
    .evt         (fault_evt),
    .frame_valid (frame_valid),
    .cmd_rd      (cmd_rd),
    .cmd_addr    (cmd_addr),
    .resp_word   (resp_word),
    .cause_o     (cause_all),
    .clr_o       (clr_mask),
    .fault_n     (fault_n)
  );
endmodule

// File: rtl/spi_fault_status_chk.sv
module spi_fault_status_chk #(
  parameter int EVT_W = 12
) (
  input logic             clk,
  input logic             rst_s,
  input logic             cs_n,
  input logic             sdo,
  input logic [EVT_W-1:0] fault_evt,
  input logic             fault_n,
  input logic [EVT_W-1:0] cause,
  input logic [EVT_W-1:0] clr,
  input logic [15:0]      resp,
  input logic             frame_valid
);
  assert_resp_hold_R1: assert property (@(posedge clk) disable iff (!rst_s)
    !frame_valid |=> $stable(resp));

  assert_sdo_idle_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo);

  assert_sum_covers_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (|cause) |-> !fault_n);

  assert_evt_sets_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (|fault_evt) |=> !fault_n);

  assert_fault_latch_R6: assert property (@(posedge clk) disable iff (!rst_s)
    !fault_n |=> !fault_n);

  assert_cause_keep_R7: assert property (@(posedge clk) disable iff (!rst_s)
    1'b1 |=> ((cause & $past(cause & ~clr)) == $past(cause & ~clr)));

  assert_clr_on_read_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (clr != '0) |-> (frame_valid && ((clr & ~cause) == '0)));

  assert_evt_wins_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (|fault_evt) |=> ((cause & $past(fault_evt)) == $past(fault_evt)));
endmodule

bind spi_fault_status spi_fault_status_chk #(.EVT_W(EVT_W)) chk_i (
  .clk         (clk),
  .rst_s       (rst_s),
  .cs_n        (cs_n),
  .sdo         (sdo),
  .fault_evt   (fault_evt),
  .fault_n     (fault_n),
  .cause       (cause_all),
  .clr         (clr_mask),
  .resp        (resp_word),
  .frame_valid (frame_valid)
);

// File: tb/spi_fault_status_tb_top.sv
`timescale 1ns/1ps
module spi_fault_status_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        sdi = 1'b0;
  logic        sdo;
  logic [11:0] fault_evt = '0;
  logic        fault_n;
  int          n_checks = 0;
  int          n_errors = 0;
  logic [15:0] w;

  always #4 clk = ~clk;

  spi_fault_status dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .fault_evt(fault_evt), .fault_n(fault_n)
  );

  task automatic chk16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // One frame of nbits clocks; optional event pulse on the acceptance edge.
  task automatic frame(input logic [15:0] mosi, input int nbits, input int evt_idx,
                       output logic [15:0] miso);
    miso = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1;
      sdi  = (i < 16) ? mosi[15-i] : 1'b0;
      repeat (6) @(negedge clk);
      if (i < 16) miso[15-i] = sdo;
      sclk = 1'b0;
      repeat (6) @(negedge clk);
    end
    cs_n = 1'b1;
    sdi  = 1'b0;
    @(negedge clk);
    @(negedge clk);
    if (evt_idx >= 0) fault_evt[evt_idx] = 1'b1;
    @(negedge clk);
    fault_evt = '0;
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse_evt(input int idx);
    @(negedge clk) fault_evt[idx] = 1'b1;
    @(negedge clk) fault_evt = '0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    chk1("R10 fault_n after reset", fault_n, 1'b1);
    chk1("R3 sdo idle", sdo, 1'b0);
    frame(16'h8000, 16, -1, w);
    chk16("R10 first response zero", w, 16'h0000);
    frame(16'h0000, 16, -1, w);
    chk16("R10 status0 clear", w, 16'h0000);
  endtask

  task automatic t_addr_echo();
    frame(16'h8800, 16, -1, w);
    frame(16'hA800, 16, -1, w);
    chk16("R2 address 1 echo", w, 16'h0800);
    frame(16'h0000, 16, -1, w);
    chk16("R4 unused address 5", w, 16'h2800);
  endtask

  task automatic t_clear_on_read();
    pulse_evt(3);
    chk1("R5 fault_n low", fault_n, 1'b0);
    frame(16'h8000, 16, -1, w);
    frame(16'h8000, 16, -1, w);
    chk16("R5 cause3 and summary", w, 16'h0408);
    frame(16'h0000, 16, -1, w);
    chk16("R7 cause cleared, summary kept", w, 16'h0400);
    chk1("R6 fault_n still low", fault_n, 1'b0);
  endtask

  task automatic t_reg1();
    pulse_evt(11);
    frame(16'h8800, 16, -1, w);
    frame(16'h8800, 16, -1, w);
    chk16("R4 event 11 at status1 bit1", w, 16'h0802);
    frame(16'h0000, 16, -1, w);
    chk16("R7 status1 cleared", w, 16'h0800);
  endtask

  task automatic t_write();
    pulse_evt(10);
    frame(16'h0FFF, 16, -1, w);
    frame(16'h8800, 16, -1, w);
    chk16("R8 write response shows content", w, 16'h0801);
    frame(16'h07FF, 16, -1, w);
    chk16("R8 write did not clear", w, 16'h0801);
    frame(16'h8800, 16, -1, w);
    chk16("R8 write to status0 set nothing", w, 16'h0400);
    frame(16'h0000, 16, -1, w);
    chk16("R7 status1 cleared after read", w, 16'h0800);
  endtask

  task automatic t_discard();
    frame(16'h8800, 16, -1, w);
    frame(16'h8000, 12, -1, w);
    frame(16'hA800, 16, -1, w);
    chk16("R1 short frame discarded", w, 16'h0800);
    frame(16'h8000, 17, -1, w);
    frame(16'h0000, 16, -1, w);
    chk16("R1 long frame discarded", w, 16'h2800);
  endtask

  task automatic t_collision();
    pulse_evt(3);
    frame(16'h8000, 16, 3, w);
    frame(16'h0000, 16, -1, w);
    chk16("R9 read returns cause3", w, 16'h0408);
    frame(16'h8000, 16, -1, w);
    chk16("R9 cause3 survived clear", w, 16'h0408);
  endtask

  task automatic t_reset_clears();
    chk1("R6 fault_n low before reset", fault_n, 1'b0);
    do_reset();
    chk1("R10 fault_n released", fault_n, 1'b1);
    frame(16'h8000, 16, -1, w);
    frame(16'h0000, 16, -1, w);
    chk16("R10 status0 zero after reset", w, 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_addr_echo();
    t_clear_on_read();
    t_reg1();
    t_write();
    t_discard();
    t_collision();
    t_reset_clears();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule